// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal access address of a synchronous burst memory. When a new cycle starts, it captures a 17-bit external address. A cycle can start from either of two address strobes, one from the processor side and one from the controller side, and the chip enable qualifications decide whether the start is accepted. On later clock edges it walks the two lowest address bits through a four-beat burst whenever an advance is requested. The upper bits never change during the burst.

A static order input picks the walk. Interleaved order XORs the start offset with the beat count. Linear order adds the beat count to the start offset, modulo four. The block reports the current access address and the index of the current beat. Read/write decode and the data path sit outside. The surrounding logic tells the block only whether the running burst is a write and whether a byte write strobe is present.

Top module: `burst_addr_seq`

## Requirements
- R1: Bits 16..2 of `curAddr` keep the value captured at the last load for the whole burst. Only bits 1..0 change when a step is taken.
- R2: With `interleave` = 1, bits 1..0 of `curAddr` equal the loaded offset XOR `beatIdx`. For a start offset of 01 the beats read 01, 00, 11, 10.
- R3: With `interleave` = 0, bits 1..0 of `curAddr` equal the loaded offset plus `beatIdx`, modulo 4. For a start offset of 01 the beats read 01, 10, 11, 00.
- R4: Each step raises `beatIdx` by one. After beat 3 it wraps to 0 and continues around the same four addresses, with no carry into bits 16..2.
- R5: A step is taken on an edge where `advance` is 1 and no effective strobe is present. An effective strobe is `ctrlStrobe`, or `procStrobe` while `masterEn` is 1. With `advance` = 0, the address and beat hold.
- R6: On any edge with an effective strobe, `advance` is ignored and no step occurs.
- R7: While `writeBurst` is 1, a step also requires `byteWrite` = 1. With `byteWrite` = 0 the address holds even if `advance` = 1.
- R8: A load happens when `masterEn` and `selectOk` are both 1 and either `procStrobe` = 1 or (`ctrlStrobe` = 1 and `procStrobe` = 0). A load captures `extAddr` and clears `beatIdx` to 0. It takes priority over a burst in progress.
- R9: With `masterEn` = 0, `procStrobe` is blocked: it neither loads nor stops a step. A strobe edge that fails the enable qualification loads nothing, and the address and beat hold.
- R10: After reset, `curAddr` = 0 and `beatIdx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| extAddr | input | 17 | External address captured on a load |
| procStrobe | input | 1 | Processor-side address strobe, asserted high |
| ctrlStrobe | input | 1 | Controller-side address strobe, asserted high |
| masterEn | input | 1 | Master chip enable; gates the processor strobe |
| selectOk | input | 1 | Remaining chip enables all active |
| advance | input | 1 | Burst advance request |
| writeBurst | input | 1 | Running burst is a write |
| byteWrite | input | 1 | At least one byte write strobe asserted |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| curAddr | output | 17 | Current access address |
| beatIdx | output | 2 | Index of the current burst beat |

## Verification
Every effect shows up exactly one clock edge after the inputs are sampled. There is no pipeline stage between the captured base/beat registers and the outputs, so a load or step sampled at one rising edge appears on `curAddr` and `beatIdx` right after that edge. The bench changes inputs shortly after a rising edge and advances exactly one edge per operation. It compares the outputs after that edge has settled. Expected addresses come from the start offset and a beat counter kept in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqCmd_t;
endpackage

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    procStrobe,
  input  logic    ctrlStrobe,
  input  logic    masterEn,
  input  logic    selectOk,
  input  logic    advance,
  input  logic    writeBurst,
  input  logic    byteWrite,
  output seqCmd_t cmd
);
  logic procEff;
  logic anyStrobe;
  logic startReq;
  logic stepOk;

  always_comb begin
    procEff   = procStrobe & masterEn;
    anyStrobe = procEff | ctrlStrobe;
    startReq  = procEff | (ctrlStrobe & ~procStrobe);
    stepOk    = advance & (~writeBurst | byteWrite);
    cmd.load  = startReq & masterEn & selectOk;
    cmd.step  = ~anyStrobe & stepOk;
  end

  AST_NO_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe || (procStrobe && masterEn)) |-> !cmd.step); // R6
  AST_WRITE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (writeBurst && !byteWrite) |-> !cmd.step); // R7
  AST_NO_LOAD_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!selectOk || !masterEn) |-> !cmd.load); // R9
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] baseHi;
  logic [BEAT_W-1:0]  baseLo;
  logic [BEAT_W-1:0]  beatCnt;
  logic [BEAT_W-1:0]  lowOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi  <= '0;
      baseLo  <= '0;
      beatCnt <= '0;
    end else if (cmd.load) begin
      baseHi  <= extAddr[ADDR_W-1:BEAT_W];
      baseLo  <= extAddr[BEAT_W-1:0];
      beatCnt <= '0;
    end else if (cmd.step) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (interleave) lowOut = baseLo ^ beatCnt;
    else            lowOut = baseLo + beatCnt;
    curAddr = {baseHi, lowOut};
    beatIdx = beatCnt;
  end

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(curAddr[ADDR_W-1:BEAT_W])); // R1
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (beatIdx == '0 && curAddr == $past(extAddr))); // R8
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.load) |=> beatIdx == BEAT_W'($past(beatIdx) + 1'b1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.step && !cmd.load) |=> $stable(beatIdx)); // R5
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              masterEn,
  input  logic              selectOk,
  input  logic              advance,
  input  logic              writeBurst,
  input  logic              byteWrite,
  input  logic              interleave,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BEAT_W-1:0] beatIdx
);
  seqCmd_t cmd;

  burst_seq_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .masterEn   (masterEn),
    .selectOk   (selectOk),
    .advance    (advance),
    .writeBurst (writeBurst),
    .byteWrite  (byteWrite),
    .cmd        (cmd)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .extAddr    (extAddr),
    .interleave (interleave),
    .curAddr    (curAddr),
    .beatIdx    (beatIdx)
  );
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] extAddr = '0;
  logic        procStrobe = 1'b0;
  logic        ctrlStrobe = 1'b0;
  logic        masterEn = 1'b1;
  logic        selectOk = 1'b1;
  logic        advance = 1'b0;
  logic        writeBurst = 1'b0;
  logic        byteWrite = 1'b0;
  logic        interleave = 1'b1;
  logic [16:0] curAddr;
  logic [1:0]  beatIdx;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .procStrobe(procStrobe),
    .ctrlStrobe(ctrlStrobe), .masterEn(masterEn), .selectOk(selectOk),
    .advance(advance), .writeBurst(writeBurst), .byteWrite(byteWrite),
    .interleave(interleave), .curAddr(curAddr), .beatIdx(beatIdx)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [16:0] expA, logic [1:0] expB);
    vectors++;
    if (curAddr !== expA || beatIdx !== expB) begin
      miscompares++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, curAddr, beatIdx, expA, expB);
    end
  endtask

  task automatic quiet();
    procStrobe = 1'b0; ctrlStrobe = 1'b0; advance = 1'b0;
    masterEn = 1'b1; selectOk = 1'b1; writeBurst = 1'b0; byteWrite = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset", 17'h0, 2'd0);
  endtask

  task automatic t_interleave();
    logic [16:0] a = 17'h1ABCD;
    interleave = 1'b1;
    extAddr = a; procStrobe = 1'b1; advance = 1'b1;
    cyc();
    procStrobe = 1'b0;
    chk("R8 proc load", a, 2'd0);
    for (int k = 1; k <= 6; k++) begin
      cyc();
      chk("R2 R4 R1 interleaved beat", {a[16:2], a[1:0] ^ 2'(k)}, 2'(k));
    end
    quiet();
  endtask

  task automatic t_linear();
    logic [16:0] a = 17'h0F3E5;
    interleave = 1'b0;
    extAddr = a; ctrlStrobe = 1'b1;
    cyc();
    ctrlStrobe = 1'b0;
    chk("R8 ctrl load", a, 2'd0);
    advance = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      cyc();
      chk("R3 R4 R1 linear beat", {a[16:2], 2'(a[1:0] + 2'(k))}, 2'(k));
    end
    advance = 1'b0;
    cyc(); cyc();
    chk("R5 hold without advance", {a[16:2], 2'(a[1:0] + 2'd1)}, 2'd1);
    quiet();
  endtask

  task automatic t_reload_mid_burst();
    logic [16:0] b = 17'h05552;
    interleave = 1'b1;
    extAddr = b; procStrobe = 1'b1; ctrlStrobe = 1'b1; advance = 1'b1;
    cyc();
    procStrobe = 1'b0; ctrlStrobe = 1'b0;
    chk("R6 R8 reload ignores advance", b, 2'd0);
    cyc();
    chk("R2 step after reload", {b[16:2], 2'b11}, 2'd1);
    ctrlStrobe = 1'b1; procStrobe = 1'b1; selectOk = 1'b0; extAddr = 17'h1FFFF;
    cyc();
    chk("R6 R9 deselect strobe holds", {b[16:2], 2'b11}, 2'd1);
    quiet();
  endtask

  task automatic t_write();
    logic [16:0] c = 17'h12340;
    interleave = 1'b0;
    extAddr = c; ctrlStrobe = 1'b1;
    cyc();
    ctrlStrobe = 1'b0;
    writeBurst = 1'b1; advance = 1'b1; byteWrite = 1'b0;
    cyc();
    chk("R7 write without byte strobe holds", c, 2'd0);
    byteWrite = 1'b1;
    cyc();
    chk("R7 write with byte strobe steps", c + 17'd1, 2'd1);
    quiet();
  endtask

  task automatic t_blocked();
    logic [16:0] d = 17'h0A00B;
    interleave = 1'b1;
    extAddr = d; procStrobe = 1'b1;
    cyc();
    chk("R8 load for blocked test", d, 2'd0);
    masterEn = 1'b0; extAddr = 17'h00004; advance = 1'b1;
    cyc();
    chk("R9 blocked proc strobe lets step", {d[16:2], 2'b10}, 2'd1);
    advance = 1'b0; ctrlStrobe = 1'b1; procStrobe = 1'b0;
    cyc();
    chk("R9 ctrl strobe without master enable", {d[16:2], 2'b10}, 2'd1);
    quiet();
  endtask

  initial begin
    #20000;
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    cyc();
    t_reset();
    t_interleave();
    t_linear();
    t_reload_mid_burst();
    t_write();
    t_blocked();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule